// File: doc/BRIEF.md
# Instruction Decode Consistency Checker

This block watches an instruction decoder that turns opcode characters into a one-hot set of intermediate lines and then into a set of enabled output gates. It checks three points along that path.

Each opcode character that enters the static decode register must carry a correct check bit. The intermediate lines must form a proper one-hot selection within each checked group and across the checked groups. The number of enabled output gates must be odd. Each decoder entry is padded with spare lines so that a correct decode always gives an odd count.

Each failure sets its own sticky flag, and the flag stays set until the clear input is raised. Any set flag raises `halt`. The `setup_block` output tells the decoder not to set up an order. It rises at once for a character that fails its parity check, and it stays high while any flag is set. Group membership and group exemptions are parameters. An exempt group is one where a multi-line fault is known to trip another check.

Top module: `decode_checker`

## Requirements
- R1: While `char_valid` is high, the character passes when `{char_chk, char_data}` holds an odd number of ones. An even number sets `err_input` at the next clock edge.
- R2: `setup_block` is high in the same cycle as a `char_valid` character that fails the R1 parity rule. It is also high in every cycle in which `halt` is high.
- R3: While `decode_valid` is high, `err_inter` is set at the next edge if any non-exempt group has more than one active line. By default, group 0 is lines 3:0, group 1 is lines 7:4 and group 2 is lines 11:8.
- R4: Group 2 is exempt by default. Several active lines inside it alone do not set `err_inter`.
- R5: While `decode_valid` is high, `err_inter` is set if the lines of all non-exempt groups taken together hold more than one active line. For example, one line in group 0 and one line in group 1 sets it.
- R6: While `decode_valid` is high, an even count of ones on `gates`, including zero, sets `err_output` at the next edge.
- R7: In a cycle where neither `char_valid` nor `decode_valid` is high, no flag is set, whatever `lines`, `gates` or the character inputs hold.
- R8: Each flag stays set until `clear` is sampled high. If a new error of the same kind arrives in the same cycle as `clear`, the flag stays set.
- R9: `halt` is high exactly when at least one of `err_input`, `err_inter` and `err_output` is set.
- R10: After reset, all flags, `halt` and `setup_block` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Clears the sticky flags |
| char_valid | input | 1 | An opcode character is being loaded |
| char_data | input | CHAR_W | Opcode character bits |
| char_chk | input | 1 | Check bit for the character (odd parity) |
| decode_valid | input | 1 | Lines and gates hold a decode to check |
| lines | input | LINES | Intermediate decoded lines |
| gates | input | GATES | Enabled output gates, padding included |
| err_input | output | 1 | Sticky character parity error |
| err_inter | output | 1 | Sticky intermediate-line error |
| err_output | output | 1 | Sticky even-gate-count error |
| halt | output | 1 | Any flag is set |
| setup_block | output | 1 | Do not set up an order |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that `clear` and the two strobes are single-cycle-sampled levels whose meaning does not depend on earlier cycles. The bench drives all inputs on the falling edge only, so they are stable through each rising edge. It holds `rst_n` low over the first edges, so the properties are disabled until the inputs have been set. The stimulus also puts junk on `lines` and `gates` with the strobes low, which covers the idle-cycle assumption.

// File: rtl/decode_checker.sv
module decode_checker #(
  parameter int CHAR_W = 6,
  parameter int LINES  = 12,
  parameter int GROUPS = 3,
  parameter int GATES  = 8,
  parameter logic [GROUPS*LINES-1:0] GROUP_MASKS = {12'hF00, 12'h0F0, 12'h00F},
  parameter logic [GROUPS-1:0]       EXEMPT      = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_chk,
  input  logic              decode_valid,
  input  logic [LINES-1:0]  lines,
  input  logic [GATES-1:0]  gates,
  output logic              err_input,
  output logic              err_inter,
  output logic              err_output,
  output logic              halt,
  output logic              setup_block
);

  logic [GROUPS-1:0] grp_multi;
  logic [LINES-1:0]  checked_mask;
  logic              char_bad, inter_bad, out_bad;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    if (EXEMPT[g]) begin : g_exempt
      assign grp_multi[g] = 1'b0;
    end else begin : g_checked
      assign grp_multi[g] = $countones(lines & GROUP_MASKS[g*LINES +: LINES]) > 1;
    end
  end

  always_comb begin
    checked_mask = '0;
    for (int g = 0; g < GROUPS; g++)
      if (!EXEMPT[g]) checked_mask |= GROUP_MASKS[g*LINES +: LINES];
  end

  assign char_bad  = char_valid && !(^{char_chk, char_data});
  assign inter_bad = decode_valid && ((|grp_multi) || ($countones(lines & checked_mask) > 1));
  assign out_bad   = decode_valid && !(^gates);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_input  <= 1'b0;
      err_inter  <= 1'b0;
      err_output <= 1'b0;
    end else begin
      err_input  <= char_bad  | (err_input  & ~clear);
      err_inter  <= inter_bad | (err_inter  & ~clear);
      err_output <= out_bad   | (err_output & ~clear);
    end
  end

  assign halt        = err_input | err_inter | err_output;
  assign setup_block = halt | char_bad;

  a_r1_parity_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && ($countones({char_chk, char_data}) % 2 == 0)) |=> err_input);

  a_r6_even_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_valid && ($countones(gates) % 2 == 0)) |=> err_output);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && (err_input || err_inter || err_output)) |=> halt);

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_valid && !decode_valid && !clear) |=>
      ($stable(err_input) && $stable(err_inter) && $stable(err_output)));

  a_r3_no_spurious_inter: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_inter && !decode_valid) |=> !err_inter);

  a_r9_halt_flags: assert property (@(posedge clk) disable iff (!rst_n)
    err_output |-> (halt && setup_block));

endmodule

// File: tb/sim_decode_checker.sv
`timescale 1ns/1ps
module sim_decode_checker;
  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic char_valid = 1'b0, char_chk = 1'b0, decode_valid = 1'b0;
  logic [5:0]  char_data = '0;
  logic [11:0] lines = '0;
  logic [7:0]  gates = '0;
  logic err_input, err_inter, err_output, halt, setup_block;

  int checks = 0, failures = 0;
  bit m_in = 0, m_it = 0, m_out = 0;

  always #10 clk = ~clk;

  decode_checker u0 (.*);

  task automatic chk(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, nm, act, exp);
    end
  endtask

  function automatic bit ref_char_bad();
    int n = char_chk;
    for (int i = 0; i < 6; i++) n += char_data[i];
    return char_valid && (n % 2 == 0);
  endfunction

  function automatic bit ref_inter_bad();
    int tot = 0;
    bit bad = 0;
    for (int g = 0; g < 2; g++) begin
      int n = 0;
      for (int i = 4*g; i < 4*g+4; i++) n += lines[i];
      if (n > 1) bad = 1;
      tot += n;
    end
    return decode_valid && (bad || tot > 1);
  endfunction

  function automatic bit ref_out_bad();
    int n = 0;
    for (int i = 0; i < 8; i++) n += gates[i];
    return decode_valid && (n % 2 == 0);
  endfunction

  task automatic cyc(string req, bit cv, logic [5:0] cd, bit ck, bit dv,
                     logic [11:0] ln, logic [7:0] gt, bit clr);
    bit cb;
    char_valid = cv; char_data = cd; char_chk = ck;
    decode_valid = dv; lines = ln; gates = gt; clear = clr;
    #1;
    cb = ref_char_bad();
    chk("R2", "setup_block", setup_block, cb | m_in | m_it | m_out);
    @(posedge clk);
    m_in  = cb              | (m_in  & ~clr);
    m_it  = ref_inter_bad() | (m_it  & ~clr);
    m_out = ref_out_bad()   | (m_out & ~clr);
    @(negedge clk);
    chk(req, "err_input",  err_input,  m_in);
    chk(req, "err_inter",  err_inter,  m_it);
    chk(req, "err_output", err_output, m_out);
    chk("R9", "halt", halt, m_in | m_it | m_out);
  endtask

  task automatic idle(string req);
    cyc(req, 0, 6'h0, 0, 0, 12'h0, 8'h0, 0);
  endtask

  task automatic clr();
    cyc("R8", 0, 6'h0, 0, 0, 12'h0, 8'h0, 1);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10", "err_input",  err_input,  0);
    chk("R10", "err_inter",  err_inter,  0);
    chk("R10", "err_output", err_output, 0);
    chk("R10", "halt",       halt,       0);
    chk("R10", "setup_block", setup_block, 0);
    // R1 good characters (odd ones)
    cyc("R1", 1, 6'b000011, 1, 0, 12'h0, 8'h0, 0);
    cyc("R1", 1, 6'b000001, 0, 0, 12'h0, 8'h0, 0);
    // R1 bad character: even ones
    cyc("R1", 1, 6'b000011, 0, 0, 12'h0, 8'h0, 0);
    idle("R8"); idle("R8");
    clr();
    idle("R8");
    // good decodes
    cyc("R3", 0, 6'h0, 0, 1, 12'h001, 8'h07, 0);
    cyc("R3", 0, 6'h0, 0, 1, 12'h020, 8'h01, 0);
    // R3 two lines in group 0
    cyc("R3", 0, 6'h0, 0, 1, 12'h003, 8'h07, 0);
    clr();
    // R4 exempt group with multiple lines
    cyc("R4", 0, 6'h0, 0, 1, 12'hF00, 8'h07, 0);
    cyc("R4", 0, 6'h0, 0, 1, 12'h310, 8'h01, 0);
    // R5 across groups
    cyc("R5", 0, 6'h0, 0, 1, 12'h011, 8'h07, 0);
    clr();
    // R6 even counts, zero included
    cyc("R6", 0, 6'h0, 0, 1, 12'h001, 8'h03, 0);
    clr();
    cyc("R6", 0, 6'h0, 0, 1, 12'h001, 8'h00, 0);
    clr();
    cyc("R6", 0, 6'h0, 0, 1, 12'h001, 8'hFF, 0);
    clr();
    // R7 junk without strobes
    cyc("R7", 0, 6'b000011, 0, 0, 12'hFFF, 8'h00, 0);
    cyc("R7", 0, 6'h0, 0, 0, 12'h033, 8'h0F, 0);
    // R8 clear loses to a new error in the same cycle
    cyc("R1", 1, 6'h0, 0, 0, 12'h0, 8'h0, 0);
    cyc("R8", 1, 6'h0, 0, 0, 12'h0, 8'h0, 1);
    clr();
    // all three at once, then clear
    cyc("R9", 1, 6'h0, 0, 1, 12'h006, 8'h00, 0);
    idle("R8");
    clr();
    idle("R8");
    for (int i = 0; i < 64; i++)
      cyc("R6", i[0], i[5:0], i[1], i[2], {i[3:0], i[5:2], i[1:0], i[5:4]}, i[7:0], i[4] & i[5]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule